// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-clock synchronous SRAM with registered address and command, a register-to-register read path and a late-write path. Each word holds two lanes, a rise lane and a fall lane, so that a double-rate access moves both beats of a cycle at once. A single-rate access moves only the rise lane. A command registered on one rising edge produces read data one cycle later. For a write, the data is taken one cycle after its command and parked in a two-entry posted-write buffer. Writes leave the buffer for the array only when a newer write pushes them out. Every read looks through the buffer, so stored data always appears current at the ports.

A continue command repeats the last read or write at the next address of a four-beat burst. The burst walks the two low address bits in linear or interleaved order, and the order is chosen when the burst starts. The output-enable input gates the data outputs without a clock. After the last read, the data outputs stay valid for one further cycle before they clear. This gives a two-cycle deselect.

Top module: `lw_sram`

## Requirements
- R1: After reset is released and before any read, rd_valid and rd_valid_f are 0 and both data outputs are zero.
- R2: cmd 3'b010 (single-rate read) registered on rising edge t makes rd_valid 1 after edge t+1, with rdata_r equal to the word's rise lane and rd_valid_f 0 and rdata_f zero.
- R3: cmd 3'b011 (double-rate read) registered on edge t makes rd_valid and rd_valid_f 1 after edge t+1, returning both lanes of the word. rd_valid_f is never 1 while rd_valid is 0.
- R4: For cmd 3'b100 or 3'b101 (write) registered on edge t, the lanes are stored from wdata_r/wdata_f as sampled on edge t+1. Values on those inputs during the command cycle itself have no effect.
- R5: A read registered in the cycle right after a write, or after several writes, returns the most recently written data for its address, including data still held in the posted-write buffer or displaced from it.
- R6: A single-rate write (3'b100) replaces only the rise lane. The fall lane keeps its previous contents. A double-rate write (3'b101) replaces both.
- R7: cmd 3'b001 (continue) repeats the preceding read or write, with its rate, at the next burst address. In linear order the two low address bits advance by 1 modulo 4 per continue, and the upper bits stay fixed.
- R8: In interleaved order the two low bits of the k-th continue are the start's low bits XOR (k mod 4).
- R9: A continue that follows a deselect (or comes first after reset) is ignored: it produces no read data and stores nothing.
- R10: After a read's data appears, a following non-read cycle keeps the same data and valid flags for one extra cycle. On the cycle after that, the outputs are cleared.
- R11: When oe is 0, rdata_r and rdata_f are zero at once, without a clock edge. rd_valid and rd_valid_f are not affected by oe.
- R12: cmd codes 3'b000, 3'b110 and 3'b111 are deselects. They end any burst.
- R13: The burst order input burst_ilv (1 = interleaved) is taken with the starting read or write. Changing it during continues does not alter the burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code, registered on the rising edge |
| addr | input | AW | Word address for read and write commands |
| burst_ilv | input | 1 | Burst order at burst start, 1 = interleaved, 0 = linear |
| wdata_r | input | DW | Write data, rise lane, taken one cycle after the command |
| wdata_f | input | DW | Write data, fall lane, taken one cycle after the command |
| oe | input | 1 | Asynchronous output enable for the data outputs |
| rdata_r | output | DW | Read data, rise lane |
| rdata_f | output | DW | Read data, fall lane |
| rd_valid | output | 1 | Rise-lane read data valid |
| rd_valid_f | output | 1 | Fall-lane read data valid (double-rate reads only) |

## Verification
The properties assume that cmd holds a known value on every rising edge after reset. They also assume that oe changes only between edges, since the data-blanking property samples it at the clock. Words never written hold undefined lanes. The stimulus therefore fills its whole address window with double-rate writes before it reads, and all random addresses and burst starts stay inside that window. Inputs are driven shortly after the falling edge, so no sampled value lands on an edge.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic          burst_ilv,
  input  logic [DW-1:0] wdata_r,
  input  logic [DW-1:0] wdata_f,
  input  logic          oe,
  output logic [DW-1:0] rdata_r,
  output logic [DW-1:0] rdata_f,
  output logic          rd_valid,
  output logic          rd_valid_f
);
  localparam int DEPTH = 1 << AW;
  localparam int BB = 2;
  localparam int NWB = 2;
  localparam logic [2:0] C_CONT = 3'b001;
  localparam logic [2:0] C_RDS  = 3'b010;
  localparam logic [2:0] C_RDD  = 3'b011;
  localparam logic [2:0] C_WRS  = 3'b100;
  localparam logic [2:0] C_WRD  = 3'b101;

  logic [DW-1:0] mem_r [DEPTH];
  logic [DW-1:0] mem_f [DEPTH];

  logic is_rd, is_wr, is_start, is_cont;
  logic op_v, op_rd, op_ddr;
  logic [AW-1:0] op_addr;

  logic b_on, b_rd, b_ddr, b_ilv;
  logic [AW-1:0] b_start;
  logic [BB-1:0] b_step, n_step, n_low;

  logic s_v, s_rd, s_ddr;
  logic [AW-1:0] s_addr;

  logic          wb_v [NWB];
  logic [AW-1:0] wb_a [NWB];
  logic [DW-1:0] wb_r [NWB];
  logic [DW-1:0] wb_f [NWB];
  logic [1:0]    wb_m [NWB];
  logic push, full, commit;

  logic [DW-1:0] hit_r, hit_f;
  logic [DW-1:0] dout_r, dout_f;
  logic ov, oddr, fresh;

  assign is_rd    = (cmd == C_RDS) || (cmd == C_RDD);
  assign is_wr    = (cmd == C_WRS) || (cmd == C_WRD);
  assign is_start = is_rd || is_wr;
  assign is_cont  = (cmd == C_CONT) && b_on;

  assign n_step  = b_step + 1'b1;
  assign n_low   = b_ilv ? (b_start[BB-1:0] ^ n_step) : (b_start[BB-1:0] + n_step);
  assign op_addr = is_start ? addr : {b_start[AW-1:BB], n_low};
  assign op_v    = is_start || is_cont;
  assign op_rd   = is_start ? is_rd : b_rd;
  assign op_ddr  = is_start ? cmd[0] : b_ddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_on    <= 1'b0;
      b_rd    <= 1'b0;
      b_ddr   <= 1'b0;
      b_ilv   <= 1'b0;
      b_start <= '0;
      b_step  <= '0;
    end else if (is_start) begin
      b_on    <= 1'b1;
      b_rd    <= is_rd;
      b_ddr   <= cmd[0];
      b_ilv   <= burst_ilv;
      b_start <= addr;
      b_step  <= '0;
    end else if (is_cont) begin
      b_step  <= n_step;
    end else begin
      b_on    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v    <= 1'b0;
      s_rd   <= 1'b0;
      s_ddr  <= 1'b0;
      s_addr <= '0;
    end else begin
      s_v    <= op_v;
      s_rd   <= op_rd;
      s_ddr  <= op_ddr;
      s_addr <= op_addr;
    end
  end

  assign push   = s_v && !s_rd;
  assign full   = wb_v[0] && wb_v[1];
  assign commit = push && full;

  always_ff @(posedge clk) begin
    if (commit) begin
      if (wb_m[0][0]) mem_r[wb_a[0]] <= wb_r[0];
      if (wb_m[0][1]) mem_f[wb_a[0]] <= wb_f[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWB; i++) begin
        wb_v[i] <= 1'b0;
        wb_a[i] <= '0;
        wb_r[i] <= '0;
        wb_f[i] <= '0;
        wb_m[i] <= '0;
      end
    end else if (push) begin
      if (full) begin
        wb_a[0] <= wb_a[1];
        wb_r[0] <= wb_r[1];
        wb_f[0] <= wb_f[1];
        wb_m[0] <= wb_m[1];
        wb_a[1] <= s_addr;
        wb_r[1] <= wdata_r;
        wb_f[1] <= wdata_f;
        wb_m[1] <= {s_ddr, 1'b1};
      end else if (wb_v[0]) begin
        wb_v[1] <= 1'b1;
        wb_a[1] <= s_addr;
        wb_r[1] <= wdata_r;
        wb_f[1] <= wdata_f;
        wb_m[1] <= {s_ddr, 1'b1};
      end else begin
        wb_v[0] <= 1'b1;
        wb_a[0] <= s_addr;
        wb_r[0] <= wdata_r;
        wb_f[0] <= wdata_f;
        wb_m[0] <= {s_ddr, 1'b1};
      end
    end
  end

  always_comb begin
    hit_r = mem_r[s_addr];
    hit_f = mem_f[s_addr];
    for (int i = 0; i < NWB; i++) begin
      if (wb_v[i] && wb_a[i] == s_addr) begin
        if (wb_m[i][0]) hit_r = wb_r[i];
        if (wb_m[i][1]) hit_f = wb_f[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_r <= '0;
      dout_f <= '0;
      ov     <= 1'b0;
      oddr   <= 1'b0;
      fresh  <= 1'b0;
    end else if (s_v && s_rd) begin
      dout_r <= hit_r;
      dout_f <= s_ddr ? hit_f : '0;
      ov     <= 1'b1;
      oddr   <= s_ddr;
      fresh  <= 1'b1;
    end else if (fresh) begin
      fresh  <= 1'b0;
    end else begin
      dout_r <= '0;
      dout_f <= '0;
      ov     <= 1'b0;
      oddr   <= 1'b0;
    end
  end

  assign rdata_r    = (ov && oe) ? dout_r : '0;
  assign rdata_f    = (ov && oddr && oe) ? dout_f : '0;
  assign rd_valid   = ov;
  assign rd_valid_f = ov && oddr;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd,
  input logic          oe,
  input logic [DW-1:0] rdata_r,
  input logic [DW-1:0] rdata_f,
  input logic          rd_valid,
  input logic          rd_valid_f
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_fall_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_f |-> rd_valid);

  assert_oe_blanks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (rdata_r == '0 && rdata_f == '0));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010 || cmd == 3'b011) |-> ##2 rd_valid);

  assert_single_rate_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010) |-> ##2 !rd_valid_f);

  assert_double_rate_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b011) |-> ##2 rd_valid_f);

  assert_two_cycle_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && cmd == 3'b000 && $past(cmd) == 3'b000) |-> ##2 !rd_valid);

  assert_idle_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && cmd[2:1] == 2'b11 && $past(cmd[2:1]) == 2'b11) |-> ##2 !rd_valid);
endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cmd(cmd),
  .oe(oe),
  .rdata_r(rdata_r),
  .rdata_f(rdata_f),
  .rd_valid(rd_valid),
  .rd_valid_f(rd_valid_f)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic [AW-1:0] addr = '0;
  logic burst_ilv = 1'b0;
  logic [DW-1:0] wdata_r = '0;
  logic [DW-1:0] wdata_f = '0;
  logic oe = 1'b1;
  logic [DW-1:0] rdata_r, rdata_f;
  logic rd_valid, rd_valid_f;

  lw_sram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .burst_ilv(burst_ilv),
    .wdata_r(wdata_r), .wdata_f(wdata_f), .oe(oe),
    .rdata_r(rdata_r), .rdata_f(rdata_f), .rd_valid(rd_valid), .rd_valid_f(rd_valid_f)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [DW-1:0] m_r [1 << AW];
  logic [DW-1:0] m_f [1 << AW];
  int s_op, s_a, s_d;
  int b_on, b_rd, b_d, b_st, b_step, b_ilv;
  logic [DW-1:0] e_r, e_f;
  int e_v, e_d, e_fresh;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_op = 0; s_a = 0; s_d = 0;
      b_on = 0; b_rd = 0; b_d = 0; b_st = 0; b_step = 0; b_ilv = 0;
      e_r = '0; e_f = '0; e_v = 0; e_d = 0; e_fresh = 0;
    end else begin
      if (s_op == 2) begin
        m_r[s_a] = wdata_r;
        if (s_d != 0) m_f[s_a] = wdata_f;
      end
      if (s_op == 1) begin
        e_r = m_r[s_a];
        e_f = (s_d != 0) ? m_f[s_a] : '0;
        e_v = 1; e_d = s_d; e_fresh = 1;
      end else if (e_fresh != 0) begin
        e_fresh = 0;
      end else begin
        e_r = '0; e_f = '0; e_v = 0; e_d = 0;
      end
      if (cmd >= 3'd2 && cmd <= 3'd5) begin
        b_on = 1; b_rd = (cmd <= 3'd3); b_d = cmd[0]; b_st = int'(addr);
        b_step = 0; b_ilv = burst_ilv;
        s_op = b_rd ? 1 : 2; s_a = b_st; s_d = b_d;
      end else if (cmd == 3'd1 && b_on != 0) begin
        b_step = (b_step + 1) % 4;
        if (b_ilv != 0) s_a = (b_st & ~3) | ((b_st & 3) ^ b_step);
        else s_a = (b_st & ~3) | (((b_st & 3) + b_step) % 4);
        s_op = b_rd ? 1 : 2; s_d = b_d;
      end else begin
        b_on = 0; s_op = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [DW-1:0] x_r, x_f;
      x_r = (e_v != 0 && oe) ? e_r : '0;
      x_f = (e_v != 0 && e_d != 0 && oe) ? e_f : '0;
      checks++;
      if (rd_valid !== (e_v != 0) || rd_valid_f !== (e_v != 0 && e_d != 0) ||
          rdata_r !== x_r || rdata_f !== x_f) begin
        errors++;
        $display("FAIL %s: got v=%b vf=%b r=%h f=%h expected v=%0d vf=%0d r=%h f=%h",
                 cur_req, rd_valid, rd_valid_f, rdata_r, rdata_f,
                 e_v, (e_v != 0 && e_d != 0), x_r, x_f);
      end
    end
  end

  task automatic cyc(input logic [2:0] c, input int a, input logic ilv,
                     input logic [DW-1:0] wr, input logic [DW-1:0] wf, input logic o);
    @(negedge clk);
    #2;
    cmd = c; addr = AW'(a); burst_ilv = ilv; wdata_r = wr; wdata_f = wf; oe = o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'b000, 0, 1'b0, '0, '0, 1'b1);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    cur_req = "R1";
    idle(3);

    cur_req = "R4";
    cyc(3'b101, 0, 1'b0, 18'h3ffff, 18'h3ffff, 1'b1);
    for (int a = 1; a < WIN; a++) cyc(3'b101, a, 1'b0, 18'h100 + 18'(a-1), 18'h200 + 18'(a-1), 1'b1);
    cyc(3'b000, 0, 1'b0, 18'h100 + 18'(WIN-1), 18'h200 + 18'(WIN-1), 1'b1);
    idle(2);

    cur_req = "R2";
    cyc(3'b010, 3, 1'b0, '0, '0, 1'b1);
    cyc(3'b010, 9, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R3";
    cyc(3'b011, 4, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 15, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R11";
    cyc(3'b011, 7, 1'b0, '0, '0, 1'b1);
    cyc(3'b000, 0, 1'b0, '0, '0, 1'b0);
    cyc(3'b000, 0, 1'b0, '0, '0, 1'b1);
    idle(2);

    cur_req = "R5";
    cyc(3'b101, 2, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 2, 1'b0, 18'h0aaaa, 18'h05555, 1'b1);
    cyc(3'b101, 5, 1'b0, '0, '0, 1'b1);
    cyc(3'b101, 6, 1'b0, 18'h01111, 18'h02222, 1'b1);
    cyc(3'b101, 5, 1'b0, 18'h03333, 18'h04444, 1'b1);
    cyc(3'b011, 6, 1'b0, 18'h05555, 18'h06666, 1'b1);
    cyc(3'b011, 5, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 2, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R6";
    cyc(3'b100, 8, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 8, 1'b0, 18'h12345, 18'h3abcd, 1'b1);
    idle(3);

    cur_req = "R7";
    cyc(3'b011, 5, 1'b0, '0, '0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    idle(3);
    cyc(3'b101, 10, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, 18'h2a0a0, 18'h1b0b0, 1'b1);
    cyc(3'b001, 0, 1'b0, 18'h2a0a1, 18'h1b0b1, 1'b1);
    cyc(3'b000, 0, 1'b0, 18'h2a0a2, 18'h1b0b2, 1'b1);
    for (int a = 8; a < 12; a++) cyc(3'b011, a, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R8";
    cyc(3'b011, 6, 1'b1, '0, '0, 1'b1);
    for (int i = 0; i < 4; i++) cyc(3'b001, 0, 1'b1, '0, '0, 1'b1);
    idle(3);
    cyc(3'b010, 13, 1'b1, '0, '0, 1'b1);
    for (int i = 0; i < 3; i++) cyc(3'b001, 0, 1'b1, '0, '0, 1'b1);
    idle(3);

    cur_req = "R13";
    cyc(3'b011, 1, 1'b1, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R9";
    cyc(3'b101, 12, 1'b0, '0, '0, 1'b1);
    cyc(3'b000, 0, 1'b0, 18'h0f0f0, 18'h30303, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, 18'h3ffff, 18'h3ffff, 1'b1);
    cyc(3'b000, 0, 1'b0, 18'h3ffff, 18'h3ffff, 1'b1);
    cyc(3'b011, 13, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 12, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R12";
    cyc(3'b011, 3, 1'b0, '0, '0, 1'b1);
    cyc(3'b110, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b111, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b001, 0, 1'b0, '0, '0, 1'b1);
    idle(3);

    cur_req = "R10";
    cyc(3'b010, 4, 1'b0, '0, '0, 1'b1);
    cyc(3'b100, 14, 1'b0, '0, '0, 1'b1);
    cyc(3'b000, 0, 1'b0, 18'h15151, '0, 1'b1);
    cyc(3'b000, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b000, 0, 1'b0, '0, '0, 1'b1);
    cyc(3'b011, 14, 1'b0, '0, '0, 1'b1);
    idle(4);

    cur_req = "R5";
    for (int i = 0; i < 400; i++)
      cyc(3'($urandom_range(0, 7)), $urandom_range(0, WIN-1), 1'($urandom),
          rnd(), rnd(), ($urandom_range(0, 5) != 0));
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule